// File: doc/BRIEF.md
# Symmetric Pulse-Width Level Converter

This block converts multi-level quantizer codes, one per sample period, into a two-level pulse stream at a fast DAC clock. Every sample occupies a frame of twice as many fast-clock cycles as there are code levels. Within each frame the output is high for a number of cycles proportional to the code. The high run sits in the middle of the frame, so each sample has at most one rising edge and one falling edge. A single-bit stream carries no error from mismatch between cells, so the same pulse can drive one or more identical unit cells. One output stream is provided per cell.

Codes arrive on a strobe that is synchronous to the fast clock and may come at any point in a frame. The block holds the newest code and applies it only when the next frame starts. The current frame is therefore never disturbed. With the default 33 levels, a frame is 66 fast cycles long, for example a 202.752 MHz DAC clock against a 3.072 MHz sample rate. A 6-bit code selects 0 to 32 high-cycle pairs.

Top module: `pwm_level_pulser`

## Requirements
- R1: A frame is exactly 2*LEVELS = 66 fast cycles, and a frame whose code is c holds the output high for exactly 2*c of those cycles.
- R2: Output slots are numbered 0 to 65 within a frame. Slot k is the k-th output cycle of the frame. For code c the output is high in slots 33-c through 32+c, which is c slots on each side of the midpoint. Slots 0 and 65 are therefore always low.
- R3: A code given with a strobe is applied from the next frame start onward. A strobe in the last cycle of a frame takes effect in the following frame. A strobe in any other cycle leaves the frame in progress unchanged. When several strobes fall in one frame, the last one wins. With no strobe, the previous code repeats.
- R4: Input codes from 33 to 63 are treated as code 32, which gives 64 high cycles.
- R5: A frame with a nonzero code has exactly one rising and one falling transition. A frame with code 0 has none.
- R6: While reset is asserted all outputs are low. The first frame after reset starts on the first clock edge after release and uses code 0, as does every later frame until a strobe arrives.
- R7: All output streams carry identical values in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast DAC clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| code_i | input | CODE_W (6) | Quantizer code; values above LEVELS-1 saturate |
| code_stb_i | input | 1 | Marks code_i as a new sample |
| pwm_o | output | NUM_STREAMS (2) | Two-level pulse streams, one per unit cell |

## Verification
The hardest situation to reach is a strobe that lands right on a frame boundary or just after one. Two other cases are also hard to reach: several strobes inside one frame, and a code held across frames with no strobe. All of them decide which code a frame uses. Directed frames place strobes in the last cycle of a frame, in the first cycle of a frame, twice within one frame, and not at all for a whole frame. Saturating codes are also directed. Random strobes with random codes then cover the rest. Every frame's high count, first and last high slot, and transition count are compared with a bench model of pending and active codes.

// File: rtl/pwm_pulser_pkg.sv
package pwm_pulser_pkg;

   // Default geometry: 33 code levels, 6-bit codes, two output streams.
   localparam int DEF_LEVELS  = 33;
   localparam int DEF_CODE_W  = 6;
   localparam int DEF_STREAMS = 2;

   // Number of fast cycles in one sample frame for a given level count.
   function automatic int frame_cycles(input int levels);
      return 2 * levels;
   endfunction

endpackage

// File: rtl/pwm_frame_counter.sv
module pwm_frame_counter #(
   parameter int FRAME_LEN = 66,
   localparam int CNT_W    = $clog2(FRAME_LEN)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   output logic [CNT_W-1:0] slot_o,
   output logic             last_o
);

   localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(FRAME_LEN - 1);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (FRAME_LEN < 4) begin : g_bad_len
         $error("pwm_frame_counter: FRAME_LEN must be at least 4");
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (cnt_q == LAST_SLOT) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign slot_o = cnt_q;
   assign last_o = (cnt_q == LAST_SLOT);

   // R1: the count wraps to zero after the final slot of a frame
   p_frame_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == LAST_SLOT) |=> (cnt_q == '0));

   // R1: inside a frame the count advances by exactly one per cycle
   p_frame_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q != LAST_SLOT) |=> (cnt_q == $past(cnt_q) + 1'b1));

   // R1: the count never leaves the frame range
   p_frame_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LAST_SLOT);

endmodule

// File: rtl/pwm_code_latch.sv
module pwm_code_latch #(
   parameter int CODE_W = 6,
   parameter int LEVELS = 33,
   localparam int MAX_CODE = LEVELS - 1,
   localparam int LVL_W    = $clog2(LEVELS)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [CODE_W-1:0] code_i,
   input  logic              code_stb_i,
   input  logic              frame_last_i,
   output logic [LVL_W-1:0]  level_o
);

   logic [LVL_W-1:0] incoming;
   logic [LVL_W-1:0] pending_q;
   logic [LVL_W-1:0] active_q;

   generate
      if (LVL_W > CODE_W) begin : g_bad_width
         $error("pwm_code_latch: CODE_W too narrow for LEVELS");
      end
      if (LEVELS < 2) begin : g_bad_levels
         $error("pwm_code_latch: LEVELS must be at least 2");
      end
   endgenerate

   // Saturate out-of-range codes to the top level.
   always_comb begin
      if (code_i > CODE_W'(MAX_CODE)) begin
         incoming = LVL_W'(MAX_CODE);
      end else begin
         incoming = LVL_W'(code_i);
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         pending_q <= '0;
         active_q  <= '0;
      end else begin
         if (code_stb_i) begin
            pending_q <= incoming;
         end
         if (frame_last_i) begin
            active_q <= code_stb_i ? incoming : pending_q;
         end
      end
   end

   assign level_o = active_q;

   // R3: the applied level only changes at a frame boundary
   p_level_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !frame_last_i |=> $stable(active_q));

   // R3: a strobe on the boundary cycle is applied in the next frame
   p_boundary_take_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frame_last_i && code_stb_i) |=> (active_q == $past(incoming)));

   // R4: the applied level never exceeds the top code
   p_level_sat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      active_q <= LVL_W'(MAX_CODE));

endmodule

// File: rtl/pwm_pulse_shaper.sv
module pwm_pulse_shaper #(
   parameter int LEVELS      = 33,
   parameter int NUM_STREAMS = 2,
   localparam int FRAME_LEN  = 2 * LEVELS,
   localparam int CNT_W      = $clog2(FRAME_LEN),
   localparam int LVL_W      = $clog2(LEVELS),
   localparam int MID        = LEVELS
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic [CNT_W-1:0]       slot_i,
   input  logic [LVL_W-1:0]       level_i,
   output logic [NUM_STREAMS-1:0] pwm_o
);

   logic [CNT_W:0] lo_bound;
   logic [CNT_W:0] hi_bound;
   logic [CNT_W:0] slot_ext;
   logic           pulse_on;

   generate
      if (NUM_STREAMS < 1) begin : g_bad_streams
         $error("pwm_pulse_shaper: NUM_STREAMS must be at least 1");
      end
   endgenerate

   // High window is [MID-level, MID+level), centred on the frame midpoint.
   always_comb begin
      slot_ext = {1'b0, slot_i};
      lo_bound = (CNT_W+1)'(MID) - (CNT_W+1)'(level_i);
      hi_bound = (CNT_W+1)'(MID) + (CNT_W+1)'(level_i);
      pulse_on = (slot_ext >= lo_bound) && (slot_ext < hi_bound);
   end

   // One retimed flop per unit cell keeps every stream's load separate.
   for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_stream
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            pwm_o[g] <= 1'b0;
         end else begin
            pwm_o[g] <= pulse_on;
         end
      end
   end

   // R2: the first and last slots of a frame are always low
   p_edge_slots_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (slot_i == '0 || slot_i == CNT_W'(FRAME_LEN - 1)) |=> (pwm_o == '0));

   // R2: a nonzero level always covers the midpoint slot
   p_mid_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (slot_i == CNT_W'(MID) && level_i != '0) |=> (pwm_o == '1));

   // R7: all streams agree
   p_streams_agree_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($countones(pwm_o) == 0) || ($countones(pwm_o) == NUM_STREAMS));

endmodule

// File: rtl/pwm_level_pulser.sv
module pwm_level_pulser #(
   parameter int LEVELS      = pwm_pulser_pkg::DEF_LEVELS,
   parameter int CODE_W      = pwm_pulser_pkg::DEF_CODE_W,
   parameter int NUM_STREAMS = pwm_pulser_pkg::DEF_STREAMS
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic [CODE_W-1:0]      code_i,
   input  logic                   code_stb_i,
   output logic [NUM_STREAMS-1:0] pwm_o
);

   localparam int FRAME_LEN = pwm_pulser_pkg::frame_cycles(LEVELS);
   localparam int CNT_W     = $clog2(FRAME_LEN);
   localparam int LVL_W     = $clog2(LEVELS);

   logic [CNT_W-1:0] slot;
   logic             frame_last;
   logic [LVL_W-1:0] level;

   pwm_frame_counter #(
      .FRAME_LEN (FRAME_LEN)
   ) u_counter (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .slot_o (slot),
      .last_o (frame_last)
   );

   pwm_code_latch #(
      .CODE_W (CODE_W),
      .LEVELS (LEVELS)
   ) u_latch (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .code_i       (code_i),
      .code_stb_i   (code_stb_i),
      .frame_last_i (frame_last),
      .level_o      (level)
   );

   pwm_pulse_shaper #(
      .LEVELS      (LEVELS),
      .NUM_STREAMS (NUM_STREAMS)
   ) u_shaper (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .slot_i  (slot),
      .level_i (level),
      .pwm_o   (pwm_o)
   );

   // R6: outputs are low in the cycle after reset is applied
   p_reset_low_r6: assert property (@(posedge clk_i)
      !rst_ni |=> (pwm_o == '0));

endmodule

// File: tb/pwm_level_pulser_tb.sv
module pwm_level_pulser_tb;

   localparam int LEVELS = 33;
   localparam int CODE_W = 6;
   localparam int NS     = 2;
   localparam int FRAME  = 2 * LEVELS;
   localparam int MID    = LEVELS;
   localparam int MAXC   = LEVELS - 1;
   localparam int FRAMES = 250;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [CODE_W-1:0] code;
   logic              stb;
   logic [NS-1:0]     pwm;

   int  checks = 0;
   int  fails  = 0;
   bit  done   = 1'b0;

   always #5 clk = ~clk;

   pwm_level_pulser #(
      .LEVELS      (LEVELS),
      .CODE_W      (CODE_W),
      .NUM_STREAMS (NS)
   ) u_dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .code_i     (code),
      .code_stb_i (stb),
      .pwm_o      (pwm)
   );

   function automatic int sat(input int c);
      return (c > MAXC) ? MAXC : c;
   endfunction

   function automatic bit exp_bit(input int slot, input int c);
      return (slot >= MID - c) && (slot < MID + c);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int unsigned seed_dummy;
      int pending_m;
      int active_m;
      int frame_code;
      int hi_cnt;
      int trans;
      int first_hi;
      int last_hi;
      bit prev;
      int dir_codes[7];

      seed_dummy = $urandom(32'd20240611);
      dir_codes = '{32, 0, 1, 40, 63, 31, 16};
      pending_m = 0;
      active_m = 0;
      frame_code = 0;
      hi_cnt = 0;
      trans = 0;
      first_hi = -1;
      last_hi = -1;
      prev = 1'b0;

      rst_n = 1'b0;
      code  = '0;
      stb   = 1'b0;
      repeat (4) begin
         @(negedge clk);
         check(pwm == '0, "R6", "output during reset", int'(pwm), 0);
      end
      // Release at a falling edge: the next rising edge is edge 1 (slot 0).
      rst_n = 1'b1;

      for (int t = 1; t <= FRAMES * FRAME; t++) begin
         int fr_in;
         int ph_in;
         int slot;
         int fr;
         bit eb;
         string tag;

         // Choose inputs seen by edge t.
         fr_in = t / FRAME;
         ph_in = t % FRAME;
         stb   = 1'b0;
         code  = '0;
         if (fr_in >= 1 && fr_in <= 7 && ph_in == 0) begin
            // Boundary-cycle strobes: frame fr_in uses this code (R3, R4).
            stb  = 1'b1;
            code = CODE_W'(dir_codes[fr_in - 1]);
         end else if (t == 8 * FRAME + 1) begin
            // First cycle of frame 8: must wait for frame 9 (R3).
            stb  = 1'b1;
            code = CODE_W'(7);
         end else if (t == 8 * FRAME + 30) begin
            // Later strobe in the same frame overrides the earlier one (R3).
            stb  = 1'b1;
            code = CODE_W'(9);
         end else if (t > 10 * FRAME) begin
            if (($urandom % 25) == 0) begin
               stb  = 1'b1;
               code = CODE_W'($urandom % 64);
            end
         end

         @(posedge clk);
         @(negedge clk);

         slot = (t - 1) % FRAME;
         fr   = (t - 1) / FRAME;
         if (slot == 0) begin
            frame_code = active_m;
            hi_cnt = 0;
            trans = 0;
            first_hi = -1;
            last_hi = -1;
         end

         eb = exp_bit(slot, active_m);
         tag = (fr == 0) ? "R6" : "R2";
         check(pwm[0] == eb, tag, $sformatf("stream0 frame %0d slot %0d", fr, slot),
               int'(pwm[0]), int'(eb));
         check(pwm[NS-1] == pwm[0], "R7", "streams equal",
               int'(pwm[NS-1]), int'(pwm[0]));

         if (pwm[0] != prev) trans++;
         prev = pwm[0];
         if (pwm[0]) begin
            hi_cnt++;
            if (first_hi < 0) first_hi = slot;
            last_hi = slot;
         end

         if (slot == FRAME - 1) begin
            if (fr == 0) tag = "R6";
            else if (fr == 4 || fr == 5) tag = "R4";
            else if (fr == 8 || fr == 9) tag = "R3";
            else tag = "R1";
            check(hi_cnt == 2 * frame_code, tag,
                  $sformatf("high count frame %0d", fr), hi_cnt, 2 * frame_code);
            check(trans == ((frame_code != 0) ? 2 : 0), "R5",
                  $sformatf("transitions frame %0d", fr), trans,
                  (frame_code != 0) ? 2 : 0);
            if (frame_code != 0) begin
               check(first_hi == MID - frame_code, "R2",
                     $sformatf("first high slot frame %0d", fr), first_hi,
                     MID - frame_code);
               check(first_hi + last_hi == FRAME - 1, "R2",
                     $sformatf("symmetry frame %0d", fr), first_hi + last_hi,
                     FRAME - 1);
            end
         end

         // Bench model of code handling at edge t (R3, R4).
         if (t % FRAME == 0) begin
            active_m = stb ? sat(int'(code)) : pending_m;
         end
         if (stb) pending_m = sat(int'(code));
      end

      // Directed outcomes: frame codes 32, 0, 1, 32, 32, 31, 16, 16, 9.
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule